// File: doc/BRIEF.md
# Two-Dimensional Cluster Issue Queue

This block sits beside an ordinary instruction queue and holds groups of dependent instructions ("clusters") that were formed upstream. Each row of the queue takes one whole cluster: the queue is `DEPTH` clusters deep and `WIDTH` instruction slots wide. A slot holds a payload and two source operands. Each source carries a tag and a ready bit.

Sources produced inside the same cluster are marked local at dispatch. Their ready bits are set as the row is written, so they never wait for a broadcast. External sources become ready when their tag appears on the wakeup bus. Each row keeps its own issue pointer. It offers the slot under the pointer when both of that slot's sources are ready, and advances past unused slots. Rows issue independently of one another, at most one instruction per row per cycle.

Rows are written at the tail and freed at the head in FIFO order. A row is freed only once every valid slot has issued and the row is the oldest one. A flush empties the whole queue in a single cycle.

Top module: `cluster_queue`

## Requirements
- R1: The queue holds at most `DEPTH` clusters. `alloc_ready` is low exactly when all `DEPTH` rows are occupied, and an allocate request made while it is low is ignored.
- R2: A source whose bit in `alloc_src_local` is 1 is ready from the cycle after allocation. A slot whose two sources are both local can therefore issue in the first cycle the row is valid.
- R3: An external source becomes ready in the cycle after any wakeup lane carries its tag with that lane's valid bit set. A match on the allocation cycle itself also counts.
- R4: Within a row, valid slots issue strictly in ascending slot order, one per cycle. A slot issues only when both of its sources are ready.
- R5: Slots whose bit in `alloc_slot_valid` is 0 are skipped and never issued. A row with no valid slot counts as finished at once.
- R6: Rows issue independently. A row that is waiting on an operand does not block issue from any other row.
- R7: `release_valid` pulses for one cycle when the head row has issued all its valid slots, and `release_entry` names that row. A finished row behind an unfinished head is not released.
- R8: While `flush` is high, no issue and no release is reported. In the next cycle the queue is empty and `alloc_ready` is high.
- R9: After reset the queue is empty, `alloc_ready` is high, and no issue or release is reported.
- R10: `issue_payload` slice `e` (bits `e*PAY_W` upward) carries the payload of the slot that row `e` issues. Slot `j` of an allocate is taken from `alloc_payload` bits `j*PAY_W` upward. Its source `s` uses tag bits `(2*j+s)*TAG_W` upward and local bit `2*j+s`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Empty the queue; suppresses issue and release this cycle |
| alloc_valid | input | 1 | Request to write a cluster at the tail |
| alloc_ready | output | 1 | A free row exists |
| alloc_slot_valid | input | WIDTH | Per-slot occupancy of the incoming cluster |
| alloc_src_tag | input | WIDTH*2*TAG_W | Source tags, two per slot |
| alloc_src_local | input | WIDTH*2 | Source produced inside the cluster |
| alloc_payload | input | WIDTH*PAY_W | Instruction payloads |
| wake_valid | input | WAKE_N | Per-lane wakeup strobe |
| wake_tag | input | WAKE_N*TAG_W | Per-lane result tag |
| issue_valid | output | DEPTH | Row e issues this cycle |
| issue_payload | output | DEPTH*PAY_W | Payload issued by each row |
| release_valid | output | 1 | Head row freed this cycle |
| release_entry | output | $clog2(DEPTH) | Index of the freed row |

## Verification
A corrupted ready bit or tag shows up as `issue_valid` for that row rising a cycle early or never rising. A stuck or misstepped issue pointer shows up on the very next issue, as a repeated or skipped payload. Head, tail or count errors show up within a few cycles, either as a release from the wrong row or as `alloc_ready` disagreeing with the number of clusters held. The reference model is compared on every cycle, so each of these faults is reported in the cycle where it first reaches a port.

// File: rtl/cq_pkg.sv
package cq_pkg;
  localparam int SRC_PER_INSN = 2;

  function automatic int ptr_bits(input int width);
    return $clog2(width + 1);
  endfunction
endpackage

// File: rtl/cq_entry.sv
module cq_entry
  import cq_pkg::*;
#(
  parameter int WIDTH  = 4,
  parameter int TAG_W  = 6,
  parameter int PAY_W  = 16,
  parameter int WAKE_N = 4,
  localparam int NSRC  = WIDTH * SRC_PER_INSN,
  localparam int PTR_W = ptr_bits(WIDTH)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     flush,
  input  logic                     load,
  input  logic                     drop,
  input  logic [WIDTH-1:0]         ld_slot_v,
  input  logic [NSRC*TAG_W-1:0]    ld_tag,
  input  logic [NSRC-1:0]          ld_local,
  input  logic [WIDTH*PAY_W-1:0]   ld_pay,
  input  logic [WAKE_N-1:0]        wake_v,
  input  logic [WAKE_N*TAG_W-1:0]  wake_tag,
  output logic                     busy,
  output logic                     done,
  output logic                     iss_v,
  output logic [PAY_W-1:0]         iss_pay
);
  logic                   busy_q;
  logic [WIDTH-1:0]       slot_v_q;
  logic [NSRC-1:0]        rdy_q;
  logic [NSRC*TAG_W-1:0]  tag_q;
  logic [WIDTH*PAY_W-1:0] pay_q;
  logic [PTR_W-1:0]       ptr_q;
  logic [NSRC-1:0]        hit_ld, hit_q;
  logic                   cur_ok;
  logic [PAY_W-1:0]       cur_pay;

  // first set bit of m at or above 'from'; WIDTH when none remains
  function automatic logic [PTR_W-1:0] seek(input logic [WIDTH-1:0] m, input int from);
    logic [PTR_W-1:0] r;
    r = PTR_W'(WIDTH);
    for (int i = WIDTH - 1; i >= 0; i--)
      if (i >= from && m[i]) r = PTR_W'(i);
    return r;
  endfunction

  function automatic logic tag_hit(input logic [TAG_W-1:0] t,
                                   input logic [WAKE_N-1:0] v,
                                   input logic [WAKE_N*TAG_W-1:0] tags);
    logic h;
    h = 1'b0;
    for (int k = 0; k < WAKE_N; k++)
      if (v[k] && tags[k*TAG_W +: TAG_W] == t) h = 1'b1;
    return h;
  endfunction

  always_comb begin
    for (int s = 0; s < NSRC; s++) begin
      hit_ld[s] = tag_hit(ld_tag[s*TAG_W +: TAG_W], wake_v, wake_tag);
      hit_q[s]  = tag_hit(tag_q[s*TAG_W +: TAG_W], wake_v, wake_tag);
    end
  end

  always_comb begin
    cur_ok  = 1'b0;
    cur_pay = '0;
    for (int i = 0; i < WIDTH; i++)
      if (PTR_W'(i) == ptr_q) begin
        cur_ok  = &rdy_q[i*SRC_PER_INSN +: SRC_PER_INSN];
        cur_pay = pay_q[i*PAY_W +: PAY_W];
      end
  end

  assign busy    = busy_q;
  assign done    = busy_q && (ptr_q == PTR_W'(WIDTH));
  assign iss_v   = busy_q && !done && cur_ok && !flush;
  assign iss_pay = cur_pay;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      slot_v_q <= '0;
      rdy_q    <= '0;
      tag_q    <= '0;
      pay_q    <= '0;
      ptr_q    <= PTR_W'(WIDTH);
    end else if (flush || drop) begin
      busy_q <= 1'b0;
    end else if (load) begin
      busy_q   <= 1'b1;
      slot_v_q <= ld_slot_v;
      tag_q    <= ld_tag;
      pay_q    <= ld_pay;
      rdy_q    <= ld_local | hit_ld;
      ptr_q    <= seek(ld_slot_v, 0);
    end else if (busy_q) begin
      rdy_q <= rdy_q | hit_q;
      if (iss_v) ptr_q <= seek(slot_v_q, int'(ptr_q) + 1);
    end
  end
endmodule

// File: rtl/cq_ctrl.sv
module cq_ctrl #(
  parameter int DEPTH  = 8,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             alloc_req,
  input  logic             head_done,
  output logic             alloc_ready,
  output logic             alloc_fire,
  output logic             release_fire,
  output logic [IDX_W-1:0] head,
  output logic [IDX_W-1:0] tail,
  output logic [CNT_W-1:0] count
);
  function automatic logic [IDX_W-1:0] wrap_inc(input logic [IDX_W-1:0] p);
    return (p == IDX_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign alloc_ready  = (count != CNT_W'(DEPTH));
  assign alloc_fire   = alloc_req && alloc_ready && !flush;
  assign release_fire = head_done && !flush;

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      head  <= '0;
      tail  <= '0;
      count <= '0;
    end else begin
      if (alloc_fire)   tail <= wrap_inc(tail);
      if (release_fire) head <= wrap_inc(head);
      case ({alloc_fire, release_fire})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/cluster_queue.sv
module cluster_queue
  import cq_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int WIDTH  = 4,
  parameter int TAG_W  = 6,
  parameter int PAY_W  = 16,
  parameter int WAKE_N = 4,
  localparam int NSRC  = WIDTH * SRC_PER_INSN,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     flush,
  input  logic                     alloc_valid,
  output logic                     alloc_ready,
  input  logic [WIDTH-1:0]         alloc_slot_valid,
  input  logic [NSRC*TAG_W-1:0]    alloc_src_tag,
  input  logic [NSRC-1:0]          alloc_src_local,
  input  logic [WIDTH*PAY_W-1:0]   alloc_payload,
  input  logic [WAKE_N-1:0]        wake_valid,
  input  logic [WAKE_N*TAG_W-1:0]  wake_tag,
  output logic [DEPTH-1:0]         issue_valid,
  output logic [DEPTH*PAY_W-1:0]   issue_payload,
  output logic                     release_valid,
  output logic [IDX_W-1:0]         release_entry
);
  logic             alloc_fire, release_fire;
  logic [IDX_W-1:0] head, tail;
  logic [CNT_W-1:0] count;
  logic [DEPTH-1:0] entry_busy, entry_done, entry_load, entry_drop;
  logic             head_done;

  assign head_done = entry_done[head];

  cq_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .flush(flush), .alloc_req(alloc_valid),
    .head_done(head_done), .alloc_ready(alloc_ready), .alloc_fire(alloc_fire),
    .release_fire(release_fire), .head(head), .tail(tail), .count(count)
  );

  for (genvar e = 0; e < DEPTH; e++) begin : g_row
    assign entry_load[e] = alloc_fire && (tail == IDX_W'(e));
    assign entry_drop[e] = release_fire && (head == IDX_W'(e));
    cq_entry #(.WIDTH(WIDTH), .TAG_W(TAG_W), .PAY_W(PAY_W), .WAKE_N(WAKE_N)) u_entry (
      .clk(clk), .rst_n(rst_n), .flush(flush),
      .load(entry_load[e]), .drop(entry_drop[e]),
      .ld_slot_v(alloc_slot_valid), .ld_tag(alloc_src_tag),
      .ld_local(alloc_src_local), .ld_pay(alloc_payload),
      .wake_v(wake_valid), .wake_tag(wake_tag),
      .busy(entry_busy[e]), .done(entry_done[e]),
      .iss_v(issue_valid[e]), .iss_pay(issue_payload[e*PAY_W +: PAY_W])
    );
  end

  assign release_valid = release_fire;
  assign release_entry = head;
endmodule

// File: rtl/cq_checker.sv
module cq_checker #(
  parameter int DEPTH  = 8,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             flush,
  input logic             alloc_ready,
  input logic             alloc_fire,
  input logic             release_fire,
  input logic [CNT_W-1:0] count,
  input logic [DEPTH-1:0] issue_valid,
  input logic [DEPTH-1:0] entry_busy,
  input logic [IDX_W-1:0] release_entry
);
  p_no_overflow_r1: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(DEPTH));
  p_full_stall_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (count == CNT_W'(DEPTH)) |-> !alloc_ready);
  p_alloc_grow_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_fire && !release_fire) |=> (count == CNT_W'($past(count) + 1'b1)));
  p_issue_owner_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_valid & ~entry_busy) == '0);
  p_release_owner_r7: assert property (@(posedge clk) disable iff (!rst_n)
    release_fire |-> entry_busy[release_entry]);
  p_flush_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> (issue_valid == '0 && !release_fire));
  p_flush_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (count == '0 && entry_busy == '0));
endmodule

bind cluster_queue cq_checker #(.DEPTH(DEPTH)) u_cq_checker (
  .clk(clk), .rst_n(rst_n), .flush(flush), .alloc_ready(alloc_ready),
  .alloc_fire(alloc_fire), .release_fire(release_fire), .count(count),
  .issue_valid(issue_valid), .entry_busy(entry_busy), .release_entry(release_entry)
);

// File: tb/test_cluster_queue.sv
`timescale 1ns/100ps
module test_cluster_queue;
  localparam int D = 8, W = 4, T = 6, P = 16, L = 4;

  logic clk = 1'b0, rst_n = 1'b0, flush = 1'b0, a_v = 1'b0;
  logic [W-1:0] a_sv = '0;
  logic [2*W*T-1:0] a_tag = '0;
  logic [2*W-1:0] a_loc = '0;
  logic [W*P-1:0] a_pay = '0;
  logic [L-1:0] w_v = '0;
  logic [L*T-1:0] w_tag = '0;
  logic a_rdy, rel_v;
  logic [D-1:0] iv;
  logic [D*P-1:0] ipay;
  logic [2:0] rel_e;

  int n_chk = 0, n_err = 0;

  always #2.5 clk = ~clk;

  cluster_queue i_cluster_queue (
    .clk(clk), .rst_n(rst_n), .flush(flush), .alloc_valid(a_v), .alloc_ready(a_rdy),
    .alloc_slot_valid(a_sv), .alloc_src_tag(a_tag), .alloc_src_local(a_loc),
    .alloc_payload(a_pay), .wake_valid(w_v), .wake_tag(w_tag),
    .issue_valid(iv), .issue_payload(ipay), .release_valid(rel_v), .release_entry(rel_e)
  );

  // reference model
  bit         m_busy[D];
  logic [W-1:0] m_sv[D], m_isd[D];
  logic [2*W-1:0] m_rdy[D];
  logic [T-1:0] m_tag[D][2*W];
  logic [P-1:0] m_pay[D][W];
  int m_head = 0, m_tail = 0, m_count = 0;

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic bit woken(input logic [T-1:0] t);
    for (int k = 0; k < L; k++) if (w_v[k] && w_tag[k*T +: T] == t) return 1'b1;
    return 1'b0;
  endfunction

  task automatic idle();
    a_v = 1'b0; w_v = '0; flush = 1'b0;
  endtask

  task automatic set_alloc(input logic [W-1:0] sv, input logic [2*W-1:0] loc, input int tb, input int pb);
    a_v = 1'b1; a_sv = sv; a_loc = loc;
    for (int s = 0; s < 2*W; s++) a_tag[s*T +: T] = T'(tb + s);
    for (int j = 0; j < W; j++) a_pay[j*P +: P] = P'(pb + j);
  endtask

  task automatic set_wake(input int lane, input int tg);
    w_v[lane] = 1'b1; w_tag[lane*T +: T] = T'(tg);
  endtask

  // compare against model, advance model, move to next negedge
  task automatic tick();
    logic [D-1:0] e_iv;
    int e_slot[D];
    bit e_rel;
    bit do_alloc;
    #1;
    for (int e = 0; e < D; e++) begin
      e_slot[e] = -1;
      for (int j = W - 1; j >= 0; j--) if (m_sv[e][j] && !m_isd[e][j]) e_slot[e] = j;
      e_iv[e] = m_busy[e] && e_slot[e] >= 0 && !flush &&
                m_rdy[e][2*e_slot[e]] && m_rdy[e][2*e_slot[e]+1];
    end
    e_rel = m_busy[m_head] && e_slot[m_head] < 0 && !flush;
    chk("R1", "alloc_ready", 64'(a_rdy), 64'(m_count < D));
    chk("R7", "release_valid", 64'(rel_v), 64'(e_rel));
    if (e_rel) chk("R7", "release_entry", 64'(rel_e), 64'(m_head));
    chk("R3 R4 R5 R6", "issue_valid", 64'(iv), 64'(e_iv));
    for (int e = 0; e < D; e++)
      if (e_iv[e]) chk("R10", "issue_payload", 64'(ipay[e*P +: P]), 64'(m_pay[e][e_slot[e]]));
    do_alloc = a_v && m_count < D;
    if (flush) begin
      for (int e = 0; e < D; e++) m_busy[e] = 1'b0;
      m_head = 0; m_tail = 0; m_count = 0;
    end else begin
      for (int e = 0; e < D; e++) if (m_busy[e]) begin
        for (int s = 0; s < 2*W; s++) if (woken(m_tag[e][s])) m_rdy[e][s] = 1'b1;
        if (e_iv[e]) m_isd[e][e_slot[e]] = 1'b1;
      end
      if (e_rel) begin
        m_busy[m_head] = 1'b0; m_head = (m_head + 1) % D; m_count--;
      end
      if (do_alloc) begin
        m_busy[m_tail] = 1'b1; m_sv[m_tail] = a_sv; m_isd[m_tail] = '0;
        for (int s = 0; s < 2*W; s++) begin
          m_tag[m_tail][s] = a_tag[s*T +: T];
          m_rdy[m_tail][s] = a_loc[s] | woken(a_tag[s*T +: T]);
        end
        for (int j = 0; j < W; j++) m_pay[m_tail][j] = a_pay[j*P +: P];
        m_tail = (m_tail + 1) % D; m_count++;
      end
    end
    @(negedge clk);
    idle();
  endtask

  initial begin
    #(5.0 * 100000);
    n_err++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    int ia, ib, seed;
    for (int e = 0; e < D; e++) begin
      m_busy[e] = 0; m_sv[e] = '0; m_isd[e] = '0; m_rdy[e] = '0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R9", "alloc_ready after reset", 64'(a_rdy), 64'd1);
    chk("R9", "issue_valid after reset", 64'(iv), 64'd0);
    chk("R9", "release_valid after reset", 64'(rel_v), 64'd0);

    // R2: all-local cluster issues in its first valid cycle
    set_alloc(4'b1111, 8'hFF, 0, 'h100);
    tick(); #1;
    chk("R2", "local row issues at once", 64'(iv[0]), 64'd1);
    chk("R2", "first slot payload", 64'(ipay[0 +: P]), 64'h100);
    repeat (6) tick();

    // R5: sparse slots and an empty cluster
    set_alloc(4'b0000, 8'hFF, 0, 'h200);
    tick(); #1;
    chk("R5", "empty row releases at once", 64'(rel_v), 64'd1);
    tick();
    set_alloc(4'b1010, 8'hFF, 0, 'h300);
    repeat (5) tick();

    // R6 and R7: waiting head does not block a younger local row
    ia = m_tail;
    set_alloc(4'b1111, 8'h00, 10, 'h400);
    tick();
    ib = m_tail;
    set_alloc(4'b0011, 8'hFF, 0, 'h500);
    tick(); #1;
    chk("R6", "younger row issues", 64'(iv[ib]), 64'd1);
    chk("R6", "waiting row idle", 64'(iv[ia]), 64'd0);
    repeat (3) tick(); #1;
    chk("R7", "finished row behind head held", 64'(rel_v), 64'd0);
    for (int t = 10; t < 18; t++) begin
      set_wake(t % L, t);
      tick();
    end
    repeat (4) tick();

    // R3: wakeup in the allocation cycle
    ia = m_tail;
    set_alloc(4'b0001, 8'h00, 20, 'h600);
    set_wake(2, 20); set_wake(3, 21);
    tick(); #1;
    chk("R3", "same-cycle wakeup captured", 64'(iv[ia]), 64'd1);
    repeat (3) tick();

    // R1: fill, then overfill
    flush = 1'b1; tick();
    for (int n = 0; n < D; n++) begin
      set_alloc(4'b1111, 8'h00, 40, 'h700 + 16*n);
      tick();
    end
    #1;
    chk("R1", "full queue stalls", 64'(a_rdy), 64'd0);
    set_alloc(4'b1111, 8'hFF, 0, 'h800);
    tick();
    set_wake(0, 40); set_wake(1, 41);
    tick();

    // R8: flush with issue pending
    flush = 1'b1;
    tick(); #1;
    chk("R8", "ready after flush", 64'(a_rdy), 64'd1);
    chk("R8", "no issue after flush", 64'(iv), 64'd0);

    // mixed traffic
    seed = 32'h1234567;
    for (int c = 0; c < 600; c++) begin
      seed = seed ^ (seed << 13); seed = seed ^ (seed >>> 17); seed = seed ^ (seed << 5);
      if (seed[0] | seed[1]) set_alloc(seed[7:4], seed[15:8], seed[19:16], c * 4);
      if (seed[20]) set_wake(0, seed[25:22] + seed[3:2]);
      if (seed[21]) set_wake(3, seed[29:26]);
      if (seed[31:26] == 6'd5) flush = 1'b1;
      tick();
    end

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule